// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition flags of a 32-bit processor core. An ALU reports each result together with its operation kind, carry or borrow, and signed overflow. When the arithmetic flag update is enabled, the block derives negative, zero, carry and overflow from those inputs and stores them. A separate enable loads a four-lane greater-or-equal vector produced by per-byte comparisons. A saturation pulse sets a sticky saturation flag. That flag remains set until software writes it back to zero.

All flags are presented as a single 32-bit status word. Software can overwrite every flag at once through a write-enable and a data word. A software write takes priority over any hardware update in the same cycle. Every flag is registered, so each change appears one clock after the edge that captures it.

Top module: `psw_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the whole status word to 0x00000000 at the next rising clock edge.
- R2: Bits 26:20 and 15:0 of `status_word` always read as zero, even after a software write of all ones.
- R3: When `nzcv_upd` is 1, bit 31 (N) loads bit 31 of `alu_result`.
- R4: When `nzcv_upd` is 1, bit 30 (Z) loads 1 exactly when `alu_result` is zero, and 0 otherwise.
- R5: When `nzcv_upd` is 1, bit 29 (C) loads `alu_carry` if `alu_op` is 0 (add), and loads the inverse of `alu_carry` if `alu_op` is 1 (subtract). On a subtract, `alu_carry` is the borrow indication.
- R6: When `nzcv_upd` is 1, bit 28 (V) loads `alu_ovf`.
- R7: When `nzcv_upd` is 0 and no software write occurs, bits 31:28 keep their value whatever the ALU inputs are.
- R8: A `sat_evt` pulse sets bit 27 (Q). Q then stays 1 through later arithmetic updates until a software write loads 0 into it.
- R9: When `ge_upd` is 1, bits 19:16 load `ge_vec`. Otherwise they keep their value.
- R10: When `sw_we` is 1, bits 31:27 and 19:16 load the same bit positions of `sw_wdata`. All other data bits are ignored.
- R11: If `sw_we` is 1 in the same cycle as `nzcv_upd`, `ge_upd` or `sat_evt`, the software data is stored and the hardware values are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 1 | Operation kind: 0 add, 1 subtract |
| alu_result | input | 32 | ALU result word |
| alu_carry | input | 1 | Carry out on add; borrow on subtract |
| alu_ovf | input | 1 | Signed overflow of the operation |
| sat_evt | input | 1 | Saturation or DSP overflow pulse |
| ge_vec | input | 4 | Per-byte greater-or-equal results |
| nzcv_upd | input | 1 | Load N, Z, C, V from the ALU this cycle |
| ge_upd | input | 1 | Load the GE field from `ge_vec` this cycle |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Assembled flag word |

## Verification
Every flag is due exactly one rising edge after the cycle in which its inputs are presented. This applies to arithmetic flags, the GE lane, sticky Q, software writes and reset. The bench changes inputs on the falling edge and waits through one rising edge. It reads `status_word` on the following falling edge, so each check observes the single register stage and nothing beyond it. Hold and sticky checks present new stimulus with the relevant enable low. They then sample at that same point, confirming that the stored value did not move.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/psw_nzcv_calc.sv
module psw_nzcv_calc
    import psw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   result,
    input  logic                carry_raw,
    input  logic                ovf,
    output nzcv_t               flags
);

    always_comb begin
        flags.n = result[DATA_W-1];
        flags.z = (result == '0);
        unique case (op)
            OP_ADD: flags.c = carry_raw;
            OP_SUB: flags.c = ~carry_raw;   // carry means no borrow
            default: flags.c = carry_raw;
        endcase
        flags.v = ovf;
    end

endmodule

// File: rtl/psw_field_reg.sv
module psw_field_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hw_en,
    input  logic [W-1:0] hw_d,
    input  logic         sw_en,
    input  logic [W-1:0] sw_d,
    output logic [W-1:0] q
);

    // Software load has priority over the hardware load.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (sw_en) begin
            q <= sw_d;
        end else if (hw_en) begin
            q <= hw_d;
        end
    end

endmodule

// File: rtl/psw_sticky_bit.sv
module psw_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic sw_en,
    input  logic sw_d,
    output logic q
);

    // Set-only from hardware; only a software write can clear it.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (sw_en) begin
            q <= sw_d;
        end else if (set_evt) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg
    import psw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int GE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_op,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              sat_evt,
    input  logic [GE_W-1:0]   ge_vec,
    input  logic              nzcv_upd,
    input  logic              ge_upd,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] status_word
);

    localparam int POS_N   = DATA_W - 1;
    localparam int POS_V   = POS_N - 3;
    localparam int POS_Q   = POS_V - 1;
    localparam int GE_LO   = 16;
    localparam int GE_HI   = GE_LO + GE_W - 1;

    alu_op_e     op_kind;
    nzcv_t       nzcv_next;
    logic [3:0]  nzcv_q;
    logic        q_flag;
    logic [GE_W-1:0] ge_q;

    assign op_kind = alu_op_e'(alu_op);

    psw_nzcv_calc #(.DATA_W(DATA_W)) u_calc (
        .op        (op_kind),
        .result    (alu_result),
        .carry_raw (alu_carry),
        .ovf       (alu_ovf),
        .flags     (nzcv_next)
    );

    psw_field_reg #(.W(4)) u_nzcv (
        .clk   (clk),
        .rst   (rst),
        .hw_en (nzcv_upd),
        .hw_d  (nzcv_next),
        .sw_en (sw_we),
        .sw_d  (sw_wdata[POS_N:POS_V]),
        .q     (nzcv_q)
    );

    psw_sticky_bit u_sat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (sat_evt),
        .sw_en   (sw_we),
        .sw_d    (sw_wdata[POS_Q]),
        .q       (q_flag)
    );

    psw_field_reg #(.W(GE_W)) u_ge (
        .clk   (clk),
        .rst   (rst),
        .hw_en (ge_upd),
        .hw_d  (ge_vec),
        .sw_en (sw_we),
        .sw_d  (sw_wdata[GE_HI:GE_LO]),
        .q     (ge_q)
    );

    // Reserved write-data bits are intentionally dropped.
    logic unused_wdata;
    assign unused_wdata = ^{sw_wdata[POS_Q-1:GE_HI+1], sw_wdata[GE_LO-1:0]};

    always_comb begin
        status_word               = '0;
        status_word[POS_N:POS_V]  = nzcv_q;
        status_word[POS_Q]        = q_flag;
        status_word[GE_HI:GE_LO]  = ge_q;
    end

endmodule

// File: rtl/psw_status_reg_chk.sv
module psw_status_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        alu_op,
    input logic [31:0] alu_result,
    input logic        alu_carry,
    input logic        alu_ovf,
    input logic        sat_evt,
    input logic [3:0]  ge_vec,
    input logic        nzcv_upd,
    input logic        ge_upd,
    input logic        sw_we,
    input logic [31:0] sw_wdata,
    input logic [31:0] status_word
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (status_word[26:20] == 7'd0) && (status_word[15:0] == 16'd0));

    p_n_load_r3: assert property (@(posedge clk) disable iff (rst)
        (nzcv_upd && !sw_we) |=> status_word[31] == $past(alu_result[31]));

    p_z_load_r4: assert property (@(posedge clk) disable iff (rst)
        (nzcv_upd && !sw_we) |=> status_word[30] == ($past(alu_result) == 32'd0));

    p_c_load_r5: assert property (@(posedge clk) disable iff (rst)
        (nzcv_upd && !sw_we) |=> status_word[29] == ($past(alu_carry) ^ $past(alu_op)));

    p_v_load_r6: assert property (@(posedge clk) disable iff (rst)
        (nzcv_upd && !sw_we) |=> status_word[28] == $past(alu_ovf));

    p_nzcv_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!nzcv_upd && !sw_we) |=> $stable(status_word[31:28]));

    p_q_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ((status_word[27] || sat_evt) && !sw_we) |=> status_word[27]);

    p_ge_path_r9: assert property (@(posedge clk) disable iff (rst)
        (ge_upd && !sw_we) |=> status_word[19:16] == $past(ge_vec));

    p_sw_wins_r11: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (status_word[31:27] == $past(sw_wdata[31:27]))
               && (status_word[19:16] == $past(sw_wdata[19:16])));

endmodule

bind psw_status_reg psw_status_reg_chk u_chk (.*);

// File: tb/psw_status_reg_bench.sv
module psw_status_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {op, result, carry/borrow, ovf, expected NZCV}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'b0110},
        {1'b0, 32'h8000_0000, 1'b0, 1'b1, 4'b1001},
        {1'b1, 32'h0000_0005, 1'b0, 1'b0, 4'b0010},
        {1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b1000},
        {1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'b0110},
        {1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'b0001},
        {1'b1, 32'h8000_0000, 1'b1, 1'b1, 4'b1001},
        {1'b0, 32'h0000_0001, 1'b1, 1'b0, 4'b0010}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alu_op = 1'b0;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0;
    logic        alu_ovf = 1'b0;
    logic        sat_evt = 1'b0;
    logic [3:0]  ge_vec = '0;
    logic        nzcv_upd = 1'b0;
    logic        ge_upd = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_word;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_status_reg u_psw_status_reg (
        .clk(clk), .rst(rst), .alu_op(alu_op), .alu_result(alu_result),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .sat_evt(sat_evt),
        .ge_vec(ge_vec), .nzcv_upd(nzcv_upd), .ge_upd(ge_upd),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .status_word(status_word)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        nzcv_upd = 1'b0; ge_upd = 1'b0; sat_evt = 1'b0; sw_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'hFFFF_FFFF;  // reset must beat this
        tick();
        chk("R1 reset clears word", status_word, 32'h0);
        rst = 1'b0;

        // R10 R2: software write of all ones, reserved bits dropped
        tick();
        idle();
        chk("R10 R2 sw write all ones", status_word, 32'hF80F_0000);

        // R1: reset after flags set
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset after write", status_word, 32'h0);

        // R3 R4 R5 R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            alu_op     = VEC[i][38];
            alu_result = VEC[i][37:6];
            alu_carry  = VEC[i][5];
            alu_ovf    = VEC[i][4];
            nzcv_upd   = 1'b1;
            tick();
            chk("R3 R4 R5 R6 nzcv vector", {28'h0, status_word[31:28]}, {28'h0, VEC[i][3:0]});
        end
        idle();

        // R7: hold with enable low (current NZCV = 0010)
        alu_op = 1'b0; alu_result = 32'h8000_0000; alu_carry = 1'b0; alu_ovf = 1'b1;
        tick();
        chk("R7 nzcv hold", {28'h0, status_word[31:28]}, 32'h2);

        // R8: saturation sets Q, later updates keep it
        sat_evt = 1'b1;
        tick();
        sat_evt = 1'b0;
        chk("R8 q set", {31'h0, status_word[27]}, 32'h1);
        alu_result = 32'h0000_0010; alu_ovf = 1'b0; nzcv_upd = 1'b1;
        tick();
        tick();
        nzcv_upd = 1'b0;
        chk("R8 q sticky", {31'h0, status_word[27]}, 32'h1);

        // R9: GE load and hold
        ge_vec = 4'hA; ge_upd = 1'b1;
        tick();
        ge_upd = 1'b0; ge_vec = 4'h5;
        chk("R9 ge load", {28'h0, status_word[19:16]}, 32'hA);
        tick();
        chk("R9 ge hold", {28'h0, status_word[19:16]}, 32'hA);

        // R10: software clears Q and loads new pattern
        sw_we = 1'b1; sw_wdata = 32'h5071_FFFF;
        tick();
        sw_we = 1'b0;
        chk("R10 sw pattern", status_word, 32'h5001_0000);

        // R11: software write beats simultaneous hardware updates
        alu_result = 32'h0; alu_carry = 1'b1; alu_op = 1'b0; alu_ovf = 1'b1;
        nzcv_upd = 1'b1; ge_upd = 1'b1; ge_vec = 4'hF; sat_evt = 1'b1;
        sw_we = 1'b1; sw_wdata = 32'h8004_0000;
        tick();
        idle();
        chk("R11 sw priority", status_word, 32'h8004_0000);

        // R8: software write of zero clears Q after a set
        sat_evt = 1'b1;
        tick();
        sat_evt = 1'b0;
        sw_we = 1'b1; sw_wdata = 32'h0;
        tick();
        sw_we = 1'b0;
        chk("R8 q cleared by sw", status_word, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule